// File: doc/BRIEF.md
# CAN Mailbox Status Flags

This block holds two per-mailbox status vectors for a 16-mailbox CAN controller: a cancel-done vector, which records that a transmit-cancel request removed a pending transmission, and a frame-waiting vector, which records that a data frame has been stored in a receive mailbox. Each bit is set by a one-cycle event pulse from the mailbox engine. The CPU clears a bit by writing a one to it.

A per-mailbox mask selects which frame-waiting events raise a shared receive interrupt flag. A global mask bit then gates that flag onto the interrupt line. The CPU reads and writes all of this state through a small register port. Mailbox 0 can only receive, so its cancel-done bit does not exist. Frame-waiting events count only for mailboxes configured to receive data frames, and received remote frames are discarded.

Top module: `can_mbox_flags`

## Requirements
- R1: After reset, every flag, the receive interrupt flag and both masks read 0, and `irq` is low.
- R2: A `cancel_done` pulse on bit n (n ≥ 1) sets cancel-done bit n (address 0). Both data and remote frames are covered.
- R3: Cancel-done bit 0 always reads 0. It is unaffected by pulses and by writes.
- R4: A `rx_store` pulse on bit n sets frame-waiting bit n (address 1) only when `rx_is_data` is 1 and `mb_rx_data_cfg[n]` is 1. Remote frames (`rx_is_data`=0) and mailboxes that are not configured leave the bit unchanged.
- R5: Writing 1s to address 0 or 1 clears the matching bits. Bits written with 0 keep their value.
- R6: When the same bit gets a set event and a clear-write in the same cycle, the set wins.
- R7: The receive interrupt flag (address 3, bit 0) is set in the cycle after a frame-waiting bit sets whose per-mailbox mask bit (address 2) is 0. Writing 1 to that flag clears it, and a later unmasked event sets it again.
- R8: `irq` equals the receive interrupt flag AND NOT the global mask (address 3, bit 1). It is combinational from those registers.
- R9: Address 2 holds the 16-bit per-mailbox mask. Address 3 bit 1 holds the global mask and is written directly. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cancel_done | input | 16 | per-mailbox cancel-completed pulses |
| rx_store | input | 16 | per-mailbox frame-stored pulses |
| rx_is_data | input | 1 | stored frame is a data frame |
| mb_rx_data_cfg | input | 16 | mailbox configured for data reception |
| wr_en | input | 1 | register write strobe |
| addr | input | 2 | register select |
| wdata | input | 16 | write data |
| rdata | output | 16 | read data for `addr` |
| irq | output | 1 | receive interrupt |

## Verification
A stuck or missed flag bit shows up in `rdata` one cycle after the event or write that should have changed it. Because of this, each sweep reads the registers back right after each stimulus. A wrong set/clear priority is caught by reads in the cycle after a collision. A faulty interrupt path shows at `irq` one cycle after the unmasked event, or at once when the global mask changes.

// File: rtl/can_mbox_flags_pkg.sv
package can_mbox_flags_pkg;
  localparam int NMB = 16;
  localparam int AW = 2;
  localparam logic [AW-1:0] A_CANCEL = 2'd0;
  localparam logic [AW-1:0] A_RXWAIT = 2'd1;
  localparam logic [AW-1:0] A_MASK   = 2'd2;
  localparam logic [AW-1:0] A_INTCTL = 2'd3;

  function automatic logic [NMB-1:0] w1c_next(input logic [NMB-1:0] cur,
      input logic [NMB-1:0] set, input logic [NMB-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/can_flag_vec.sv
module can_flag_vec #(
  parameter int W = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_ev,
  input  logic [W-1:0] clr_ev,
  output logic [W-1:0] flags
);
  logic [W-1:0] q;
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_live
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= (q[i] & ~clr_ev[i]) | set_ev[i];
    end else begin : g_tied
      assign q[i] = 1'b0;
    end
  end
  assign flags = q;

  // R6: a set event always wins over a clear in the same cycle
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_ev & IMPL)) |=> ((flags & $past(set_ev & IMPL)) == $past(set_ev & IMPL)));
endmodule

// File: rtl/can_rx_irq.sv
module can_rx_irq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rx_set,
  input  logic [W-1:0] mb_mask,
  input  logic         clr,
  input  logic         gmask,
  output logic         flag,
  output logic         irq
);
  logic hit;
  assign hit = |(rx_set & ~mb_mask);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag & ~clr) | hit;
  assign irq = flag & ~gmask;

  // R7: an unmasked receive event raises the flag next cycle
  p_flag_after_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  // R7: flag never rises without an unmasked event
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));
endmodule

// File: rtl/can_mbox_flags.sv
module can_mbox_flags
  import can_mbox_flags_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NMB-1:0]  cancel_done,
  input  logic [NMB-1:0]  rx_store,
  input  logic            rx_is_data,
  input  logic [NMB-1:0]  mb_rx_data_cfg,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NMB-1:0]  wdata,
  output logic [NMB-1:0]  rdata,
  output logic            irq
);
  localparam logic [NMB-1:0] TX_CAPABLE = {{(NMB-1){1'b1}}, 1'b0};

  logic [NMB-1:0] cancel_flags, rx_flags, mb_mask;
  logic [NMB-1:0] clr_cancel, clr_rx, rx_set;
  logic           gmask, int_flag, clr_int;

  assign rx_set     = rx_store & mb_rx_data_cfg & {NMB{rx_is_data}};
  assign clr_cancel = (wr_en && addr == A_CANCEL) ? wdata : '0;
  assign clr_rx     = (wr_en && addr == A_RXWAIT) ? wdata : '0;
  assign clr_int    = wr_en && addr == A_INTCTL && wdata[0];

  can_flag_vec #(.W(NMB), .IMPL(TX_CAPABLE)) u_cancel (
    .clk(clk), .rst_n(rst_n), .set_ev(cancel_done), .clr_ev(clr_cancel),
    .flags(cancel_flags));

  can_flag_vec #(.W(NMB), .IMPL('1)) u_rxwait (
    .clk(clk), .rst_n(rst_n), .set_ev(rx_set), .clr_ev(clr_rx),
    .flags(rx_flags));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mb_mask <= '0;
      gmask   <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_MASK)   mb_mask <= wdata;
      if (addr == A_INTCTL) gmask   <= wdata[1];
    end

  can_rx_irq #(.W(NMB)) u_irq (
    .clk(clk), .rst_n(rst_n), .rx_set(rx_set), .mb_mask(mb_mask),
    .clr(clr_int), .gmask(gmask), .flag(int_flag), .irq(irq));

  always_comb
    unique case (addr)
      A_CANCEL: rdata = cancel_flags;
      A_RXWAIT: rdata = rx_flags;
      A_MASK:   rdata = mb_mask;
      default:  rdata = {{(NMB-2){1'b0}}, gmask, int_flag};
    endcase

  // R3: cancel-done bit 0 never reads 1
  p_bit0_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cancel_flags[0]);
  // R4: remote frames never set a frame-waiting bit
  p_remote_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_is_data && !wr_en) |=> $stable(rx_flags));
  // R5: a bit with no set event and no clear holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cancel_done == '0) |=> $stable(cancel_flags));
  // R8: irq follows flag and global mask
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (int_flag && !gmask));
endmodule

// File: tb/can_mbox_flags_tb.sv
module can_mbox_flags_tb;
  logic clk = 0, rst_n = 0;
  logic [15:0] cancel_done = 0, rx_store = 0, mb_rx_data_cfg = 0, wdata = 0;
  logic rx_is_data = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [15:0] rdata;
  logic irq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  can_mbox_flags u_dut (.*);

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step; @(posedge clk); #2; cancel_done = 0; rx_store = 0; wr_en = 0; endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1; step();
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  logic [15:0] v, mcan, mrx;

  initial begin
    #25; rst_n = 1; @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a[1:0], v); chk("R1", v, 0); end
    chk("R1 irq", {15'b0, irq}, 0);

    // R2/R3 sweep each mailbox cancel pulse
    mcan = 0;
    for (int n = 0; n < 16; n++) begin
      cancel_done = 16'h1 << n; step();
      mcan |= (16'h1 << n) & 16'hFFFE;
      rd(0, v); chk(n == 0 ? "R3" : "R2", v, mcan);
    end
    // R3 write to bit0 ignored, R5 partial clear
    wr(0, 16'h00F1); mcan &= ~16'h00F1;
    rd(0, v); chk("R5", v, mcan);
    wr(0, 16'h0000); rd(0, v); chk("R5 zero write", v, mcan);
    // R6 collision
    cancel_done = 16'h0100; addr = 0; wdata = 16'h0300; wr_en = 1; step();
    mcan = (mcan & ~16'h0300) | 16'h0100;
    rd(0, v); chk("R6", v, mcan);

    // R4 sweep over cfg and frame type, mask all to keep irq off
    wr(2, 16'hFFFF);
    for (int k = 0; k < 8; k++) begin
      wr(1, 16'hFFFF); mrx = 0;
      mb_rx_data_cfg = 16'hA5C3 ^ (16'h1111 * k[3:0]);
      rx_is_data = k[0];
      rx_store = 16'h0F0F << k;
      step();
      mrx = rx_is_data ? (rx_store_last(k) & mb_rx_data_cfg) : 16'h0;
      rd(1, v); chk("R4", v, mrx);
    end
    rd(3, v); chk("R7 masked", v, 0);

    // R7/R8 interrupt path
    wr(2, 16'hFFFB); mb_rx_data_cfg = 16'hFFFF; rx_is_data = 1;
    rx_store = 16'h0001; step(); rd(3, v); chk("R7 masked mb", v, 0);
    rx_store = 16'h0004; step(); rd(3, v); chk("R7 set", v, 1);
    chk("R8 irq", {15'b0, irq}, 1);
    wr(3, 16'h0002); rd(3, v); chk("R9 gmask", v, 3);
    chk("R8 gated", {15'b0, irq}, 0);
    wr(3, 16'h0003); rd(3, v); chk("R7 clear", v, 2);
    wr(3, 16'h0000); chk("R8 low", {15'b0, irq}, 0);
    rx_store = 16'h0004; step(); chk("R7 reset again", {15'b0, irq}, 1);
    rd(2, v); chk("R9 mask", v, 16'hFFFB);
    rd(2, v); chk("R9 no side effect", v, 16'hFFFB);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [15:0] rx_store_last(int k);
    return 16'h0F0F << k;
  endfunction
endmodule